// File: doc/BRIEF.md
# Width-Configurable Serial Word Queues

This block sits between a host register interface and a serial shift engine. It holds two queues of equal depth. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. One width setting applies to both queues and gives each entry one to four bytes. Bytes above that width are zeroed when a word enters a queue.

Software programs a configuration word. That word holds a fill threshold for each queue, the entry width, and two self-clearing flush commands. Software can read the fill level of both queues from a status word.

Each direction has three parts:
- a flag view, which mixes live level conditions with a sticky "select released" event;
- an enable mask;
- a write-one-to-clear port.

Each direction drives its own interrupt line. A separate pair of sticky fault bits records host accesses that were refused: a push into a full transmit queue, and a pop from an empty receive queue.

Top module: `spiq_core`

## Requirements
- R1: After reset both queue levels read 0. The transmit flag view reads 8'h02, which is empty only. The receive flag view, both enable masks and the fault bits read 0, and both interrupts are low.
- R2: The status word reports the receive level in bits 12:8 and the transmit level in bits 20:16. Each level is a 5-bit count of stored entries, from 0 to 16, and it is updated on the clock edge of the accepted push or pop.
- R3: The configuration word holds the receive threshold in bits 3:0, the transmit threshold in bits 7:4 and the entry width in bits 9:8. The width is coded as the number of bytes minus one. Any pushed word keeps only its low (code+1) bytes, and its upper bytes are stored as zero.
- R4: Each queue returns words in the order they were pushed. The transmit head is shown on `eng_tdata` and the receive head is shown on `host_rdata`.
- R5: Transmit flag bit 0 is set while that queue holds 16 entries, and bit 1 is set while it holds none. A push into a full queue of either direction is dropped, and its level stays at 16.
- R6: A host push into a full transmit queue sets fault bit 0. A host pop from an empty receive queue sets fault bit 1, and the receive level stays 0. Fault bits stay set until a fault-clear write with a 1 in that bit position.
- R7: Receive flag bit 5 is set while the receive level is greater than or equal to the receive threshold. A threshold of 0 counts as 16.
- R8: Writing a configuration word with bit 11 set empties the receive queue on that clock edge. Writing one with bit 12 set empties the transmit queue on that clock edge. The other queue is left unchanged. Bits 11 and 12 always read back as 0.
- R9: A pulse on `eng_sel_rel` sets bit 6 in both flag views. That bit stays set until a 1 is written to bit 6 of that direction's clear port. Clearing one direction leaves the other direction's bit unchanged.
- R10: Each interrupt output is high exactly while its own flag view ANDed with its own enable mask is nonzero. The enable masks keep only the defined flag bits: 0, 1 and 6 for transmit, and 5 and 6 for receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write value |
| cfg_rdata | output | 32 | Configuration word readback |
| stat_rdata | output | 32 | Status word holding both queue levels |
| txe_we | input | 1 | Transmit enable mask write strobe |
| rxe_we | input | 1 | Receive enable mask write strobe |
| en_wdata | input | 8 | Enable mask write value |
| txe_rdata | output | 8 | Transmit enable mask |
| rxe_rdata | output | 8 | Receive enable mask |
| txc_we | input | 1 | Transmit flag clear strobe |
| rxc_we | input | 1 | Receive flag clear strobe |
| fltc_we | input | 1 | Fault clear strobe |
| clr_wdata | input | 8 | Write-one-to-clear value |
| txf_rdata | output | 8 | Transmit flag view |
| rxf_rdata | output | 8 | Receive flag view |
| flt_rdata | output | 2 | Sticky fault bits |
| host_push | input | 1 | Host push into the transmit queue |
| host_wdata | input | 32 | Host transmit word |
| host_pop | input | 1 | Host pop from the receive queue |
| host_rdata | output | 32 | Receive queue head |
| eng_pop | input | 1 | Engine pop from the transmit queue |
| eng_tdata | output | 32 | Transmit queue head |
| eng_tavail | output | 1 | Transmit queue not empty |
| eng_push | input | 1 | Engine push into the receive queue |
| eng_rdata_in | input | 32 | Engine receive word |
| eng_sel_rel | input | 1 | Select released event pulse |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The queues are exercised with the same word, 32'hAABBCCDD, pushed under different width codes. The popped value then shows whether the byte lanes are masked per code or passed through whole. Fill-to-capacity runs with one extra push separate a correct full guard from a queue that wraps or miscounts. Receive fills checked at one below and at the threshold, for both a small threshold and 0, show whether the comparison is off by one and whether 0 is handled as 16. Flush, clear and interrupt patterns are applied to one direction at a time, so that leakage into the other queue or flag view is visible.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
   // configuration word field positions
   localparam int CFG_RXTHR_LSB = 0;
   localparam int CFG_TXTHR_LSB = 4;
   localparam int CFG_WID_LSB   = 8;
   localparam int CFG_RXFLUSH   = 11;
   localparam int CFG_TXFLUSH   = 12;
   // status word level positions
   localparam int STAT_RXLVL_LSB = 8;
   localparam int STAT_TXLVL_LSB = 16;
   // flag bit positions
   localparam int FLG_FULL  = 0;
   localparam int FLG_EMPTY = 1;
   localparam int FLG_ABOVE = 5;
   localparam int FLG_REL   = 6;
   localparam logic [7:0] TX_LIVE_MASK   = 8'h03;
   localparam logic [7:0] RX_LIVE_MASK   = 8'h20;
   localparam logic [7:0] STICKY_MASK    = 8'h40;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
   parameter  int DEPTH = 16,
   parameter  int DW    = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1,
   localparam int NB    = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [1:0]    width,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [DW-1:0] lane_mask;
   logic          do_wr, do_rd;

   if ((DW % 8) != 0 || NB > 4 || NB < 1) begin : g_bad_dw
      $error("spiq_fifo: DW must be 8, 16, 24 or 32");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("spiq_fifo: DEPTH must be a power of two");
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane_mask[g*8 +: 8] = (g <= int'(width)) ? 8'hFF : 8'h00;
   end

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign do_wr = wr && !full && !flush;
   assign do_rd = rd && !empty && !flush;
   assign rdata = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata & lane_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         level <= level + LW'(do_wr) - LW'(do_rd);
      end
   end

   assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && full && !rd && !flush) |=> (level == $past(level)));
   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));
   assert_push_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !full && !rd && !flush) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/spiq_flags.sv
module spiq_flags #(
   parameter int         FW     = 8,
   parameter logic [7:0] LIVE   = 8'h00,
   parameter logic [7:0] STICKY = 8'h40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] live,
   input  logic [FW-1:0] set,
   input  logic          en_we,
   input  logic [FW-1:0] en_wdata,
   input  logic          clr_we,
   input  logic [FW-1:0] clr_wdata,
   output logic [FW-1:0] flags,
   output logic [FW-1:0] en,
   output logic          irq
);
   localparam logic [FW-1:0] LMASK = FW'(LIVE);
   localparam logic [FW-1:0] SMASK = FW'(STICKY);
   logic [FW-1:0] sticky, clr_v;

   assign clr_v = clr_we ? clr_wdata : '0;
   assign flags = (live & LMASK) | sticky;
   assign irq   = |(flags & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         en     <= '0;
      end else begin
         sticky <= ((sticky & ~clr_v) | set) & SMASK;
         if (en_we) en <= en_wdata & (LMASK | SMASK);
      end
   end

   assert_set_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set & SMASK)) |=> ((sticky & $past(set & SMASK)) == $past(set & SMASK)));
   assert_clear_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && |(clr_wdata & ~set & SMASK)) |=>
      ((sticky & $past(clr_wdata & ~set & SMASK)) == '0));
endmodule

// File: rtl/spiq_core.sv
module spiq_core #(
   parameter  int DEPTH = 16,
   parameter  int DW    = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   output logic [31:0]   stat_rdata,
   input  logic          txe_we,
   input  logic          rxe_we,
   input  logic [7:0]    en_wdata,
   output logic [7:0]    txe_rdata,
   output logic [7:0]    rxe_rdata,
   input  logic          txc_we,
   input  logic          rxc_we,
   input  logic          fltc_we,
   input  logic [7:0]    clr_wdata,
   output logic [7:0]    txf_rdata,
   output logic [7:0]    rxf_rdata,
   output logic [1:0]    flt_rdata,
   input  logic          host_push,
   input  logic [DW-1:0] host_wdata,
   input  logic          host_pop,
   output logic [DW-1:0] host_rdata,
   input  logic          eng_pop,
   output logic [DW-1:0] eng_tdata,
   output logic          eng_tavail,
   input  logic          eng_push,
   input  logic [DW-1:0] eng_rdata_in,
   input  logic          eng_sel_rel,
   output logic          tx_irq,
   output logic          rx_irq
);
   import spiq_pkg::*;

   if (DEPTH > 16) begin : g_bad_depth
      $error("spiq_core: DEPTH above 16 does not fit the 4-bit thresholds");
   end

   logic [3:0]    rx_thr, tx_thr;
   logic [1:0]    width;
   logic          rx_flush, tx_flush;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [LW-1:0] tx_level, rx_level;
   logic [LW-1:0] rx_eff_thr;
   logic [7:0]    tx_live, rx_live, rel_set;
   logic [1:0]    flt;

   assign rx_flush = cfg_we && cfg_wdata[CFG_RXFLUSH];
   assign tx_flush = cfg_we && cfg_wdata[CFG_TXFLUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_thr <= '0;
         tx_thr <= '0;
         width  <= '0;
      end else if (cfg_we) begin
         rx_thr <= cfg_wdata[CFG_RXTHR_LSB +: 4];
         tx_thr <= cfg_wdata[CFG_TXTHR_LSB +: 4];
         width  <= cfg_wdata[CFG_WID_LSB +: 2];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[CFG_RXTHR_LSB +: 4] = rx_thr;
      cfg_rdata[CFG_TXTHR_LSB +: 4] = tx_thr;
      cfg_rdata[CFG_WID_LSB +: 2]   = width;
      stat_rdata = '0;
      stat_rdata[STAT_RXLVL_LSB +: 5] = 5'(rx_level);
      stat_rdata[STAT_TXLVL_LSB +: 5] = 5'(tx_level);
   end

   spiq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .width(width),
      .wr(host_push), .wdata(host_wdata), .rd(eng_pop), .rdata(eng_tdata),
      .full(tx_full), .empty(tx_empty), .level(tx_level));

   spiq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .width(width),
      .wr(eng_push), .wdata(eng_rdata_in), .rd(host_pop), .rdata(host_rdata),
      .full(rx_full), .empty(rx_empty), .level(rx_level));

   assign eng_tavail = !tx_empty;
   assign rx_eff_thr = (rx_thr == '0) ? LW'(DEPTH) : LW'(rx_thr);

   always_comb begin
      tx_live = '0;
      tx_live[FLG_FULL]  = tx_full;
      tx_live[FLG_EMPTY] = tx_empty;
      rx_live = '0;
      rx_live[FLG_ABOVE] = (rx_level >= rx_eff_thr);
      rel_set = '0;
      rel_set[FLG_REL] = eng_sel_rel;
   end

   spiq_flags #(.FW(8), .LIVE(TX_LIVE_MASK), .STICKY(STICKY_MASK)) u_txflg (
      .clk(clk), .rst_n(rst_n), .live(tx_live), .set(rel_set),
      .en_we(txe_we), .en_wdata(en_wdata), .clr_we(txc_we), .clr_wdata(clr_wdata),
      .flags(txf_rdata), .en(txe_rdata), .irq(tx_irq));

   spiq_flags #(.FW(8), .LIVE(RX_LIVE_MASK), .STICKY(STICKY_MASK)) u_rxflg (
      .clk(clk), .rst_n(rst_n), .live(rx_live), .set(rel_set),
      .en_we(rxe_we), .en_wdata(en_wdata), .clr_we(rxc_we), .clr_wdata(clr_wdata),
      .flags(rxf_rdata), .en(rxe_rdata), .irq(rx_irq));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flt <= '0;
      else begin
         flt <= (flt & ~(fltc_we ? clr_wdata[1:0] : 2'b00))
              | {host_pop && rx_empty, host_push && tx_full && !tx_flush};
      end
   end
   assign flt_rdata = flt;

   assert_ovf_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_push && tx_full && !tx_flush) |=> flt[0]);
   assert_udf_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_pop && rx_empty) |=> (flt[1] && rx_level == '0));
endmodule

// File: tb/spiq_core_tb.sv
module spiq_core_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0, txe_we = 0, rxe_we = 0, txc_we = 0, rxc_we = 0, fltc_we = 0;
   logic [31:0] cfg_wdata = '0, host_wdata = '0, eng_rdata_in = '0;
   logic [7:0]  en_wdata = '0, clr_wdata = '0;
   logic        host_push = 0, host_pop = 0, eng_pop = 0, eng_push = 0, eng_sel_rel = 0;
   logic [31:0] cfg_rdata, stat_rdata, host_rdata, eng_tdata;
   logic [7:0]  txe_rdata, rxe_rdata, txf_rdata, rxf_rdata;
   logic [1:0]  flt_rdata;
   logic        eng_tavail, tx_irq, rx_irq;

   int checks = 0, errors = 0;
   logic [31:0] exp_tx[$], exp_rx[$];
   logic [1:0]  width_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spiq_core u_dut (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask(logic [31:0] d);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++) if (i <= int'(width_m)) m[i*8 +: 8] = 8'hFF;
      return d & m;
   endfunction

   task automatic tick; @(negedge clk); endtask

   task automatic wr_cfg(logic [31:0] v);
      cfg_wdata = v; cfg_we = 1; tick; cfg_we = 0;
      width_m = v[9:8];
      if (v[12]) exp_tx.delete();
      if (v[11]) exp_rx.delete();
   endtask

   task automatic tx_push(logic [31:0] d);
      host_wdata = d; host_push = 1;
      if (exp_tx.size() < 16) exp_tx.push_back(wmask(d));
      tick; host_push = 0;
   endtask

   task automatic tx_pop; eng_pop = 1; tick; eng_pop = 0; endtask

   task automatic rx_push(logic [31:0] d);
      eng_rdata_in = d; eng_push = 1;
      if (exp_rx.size() < 16) exp_rx.push_back(wmask(d));
      tick; eng_push = 0;
   endtask

   task automatic rx_pop; host_pop = 1; tick; host_pop = 0; endtask

   // scoreboard monitor: compares queue heads as they are consumed
   always @(posedge clk) begin
      if (rst_n && eng_pop && exp_tx.size() > 0) check("R4 tx order", eng_tdata, exp_tx.pop_front());
      if (rst_n && host_pop && exp_rx.size() > 0) check("R4 rx order", host_rdata, exp_rx.pop_front());
   end

   task automatic finish_sim;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      repeat (3) tick;
      rst_n = 1;
      tick;
      // R1 reset state
      check("R1 status", stat_rdata, 32'h0);
      check("R1 txflags", {24'h0, txf_rdata}, 32'h02);
      check("R1 rxflags", {24'h0, rxf_rdata}, 32'h0);
      check("R1 en/flt/irq", {txe_rdata, rxe_rdata, 14'h0, flt_rdata, tx_irq, rx_irq}, 32'h0);

      // R3 width 4 bytes, rx threshold 4
      wr_cfg(32'h0000_0304);
      check("R3 cfg readback", cfg_rdata, 32'h0000_0304);
      tx_push(32'h1111_2222); tx_push(32'h3333_4444); tx_push(32'hAABB_CCDD);
      check("R2 tx level 3", stat_rdata, 32'h0003_0000);
      check("R5 not empty", {31'h0, txf_rdata[1]}, 32'h0);
      repeat (3) tx_pop();
      check("R5 empty again", {24'h0, txf_rdata}, 32'h02);

      // R3 masking for width codes 0 and 1
      wr_cfg(32'h0000_0004);
      tx_push(32'hAABB_CCDD);
      check("R3 width1 head", eng_tdata, 32'h0000_00DD);
      tx_pop();
      wr_cfg(32'h0000_0104);
      tx_push(32'hAABB_CCDD);
      check("R3 width2 head", eng_tdata, 32'h0000_CCDD);
      tx_pop();

      // R5/R6 fill transmit queue, overflow push
      wr_cfg(32'h0000_0304);
      for (int i = 0; i < 16; i++) tx_push(32'h100 + i);
      check("R5 full flag", {24'h0, txf_rdata}, 32'h01);
      tx_push(32'hDEAD_BEEF);
      check("R5 level held 16", stat_rdata, 32'h0010_0000);
      check("R6 overflow fault", {30'h0, flt_rdata}, 32'h1);
      tx_pop(); tx_pop();
      // R8 transmit flush, flush bits read zero
      wr_cfg(32'h0000_1304);
      check("R8 tx flushed", stat_rdata, 32'h0);
      check("R8 flush bits read 0", cfg_rdata, 32'h0000_0304);
      fltc_we = 1; clr_wdata = 8'h01; tick; fltc_we = 0;
      check("R6 fault cleared", {30'h0, flt_rdata}, 32'h0);

      // R7 threshold 4
      rx_push(32'hA1); rx_push(32'hA2); rx_push(32'hA3);
      check("R7 below thr", {31'h0, rxf_rdata[5]}, 32'h0);
      rx_push(32'hA4);
      check("R7 at thr", {24'h0, rxf_rdata}, 32'h20);
      en_wdata = 8'hFF; rxe_we = 1; tick; rxe_we = 0;
      check("R10 rx enable mask", {24'h0, rxe_rdata}, 32'h60);
      check("R10 rx irq", {30'h0, tx_irq, rx_irq}, 32'h1);
      repeat (4) rx_pop();
      check("R10 rx irq low", {30'h0, tx_irq, rx_irq}, 32'h0);
      rx_pop();
      check("R6 underflow fault", {30'h0, flt_rdata}, 32'h2);
      check("R6 rx level stays 0", stat_rdata, 32'h0);

      // R7 threshold 0 means 16, R5 rx drop, R8 rx flush isolation
      wr_cfg(32'h0000_0300);
      for (int i = 0; i < 15; i++) rx_push(32'h200 + i);
      check("R7 thr0 at 15", {31'h0, rxf_rdata[5]}, 32'h0);
      rx_push(32'h20F);
      check("R7 thr0 at 16", {31'h0, rxf_rdata[5]}, 32'h1);
      rx_push(32'h999);
      check("R5 rx drop at 16", stat_rdata, 32'h0000_1000);
      rx_pop();
      tx_push(32'h55); tx_push(32'h66);
      wr_cfg(32'h0000_0B00);
      check("R8 rx flush only", stat_rdata, 32'h0002_0000);
      tx_pop(); tx_pop();

      // R9 select released, R10 tx irq
      en_wdata = 8'h00; rxe_we = 1; tick; rxe_we = 0;
      en_wdata = 8'h40; txe_we = 1; tick; txe_we = 0;
      check("R10 tx irq off", {30'h0, tx_irq, rx_irq}, 32'h0);
      eng_sel_rel = 1; tick; eng_sel_rel = 0;
      check("R9 tx released", {24'h0, txf_rdata}, 32'h42);
      check("R9 rx released", {24'h0, rxf_rdata}, 32'h40);
      check("R10 tx irq on", {30'h0, tx_irq, rx_irq}, 32'h2);
      clr_wdata = 8'h40; txc_we = 1; tick; txc_we = 0;
      check("R9 tx cleared", {24'h0, txf_rdata}, 32'h02);
      check("R9 rx kept", {24'h0, rxf_rdata}, 32'h40);
      clr_wdata = 8'hFF; rxc_we = 1; tick; rxc_we = 0;
      check("R9 rx cleared", {24'h0, rxf_rdata}, 32'h0);
      en_wdata = 8'hFF; txe_we = 1; tick; txe_we = 0;
      check("R10 tx enable mask", {24'h0, txe_rdata}, 32'h43);
      check("R10 tx irq empty", {30'h0, tx_irq, rx_irq}, 32'h2);
      if (exp_tx.size() != 0 || exp_rx.size() != 0) check("R4 drained", 32'h1, 32'h0);
      finish_sim();
   end
endmodule